// File: doc/BRIEF.md
# Double-Buffered Tile Sequencer for a Systolic Matrix Multiplier

This block wraps an output-stationary systolic array for signed 8-bit matrix multiplication (C = A × B, with A of M×K and B of K×N) and runs it one tile at a time. It holds two operand banks. One bank is active and feeds the array. The other is shadow and takes host writes. The host writes the next tile into the shadow bank over a plain address/data/enable port, then pulses `start`. The sequencer swaps the banks in a single cycle and reads K steps out of the new active bank. It drives the array's per-step valid and clear strobes and captures the packed M×N result into an output register, which comes with a one-cycle ready pulse.

The host can load tile i+1 while tile i is still streaming, so loading and computing overlap. The sequencer keeps the array's launch rule. Before a new tile enters, at least (M−1)+(N−1) idle steps must pass, so that every accumulator's final value is captured before it is cleared. A start that arrives while a tile is in flight is remembered and carried out as soon as that gap has passed.

Top module: `pingpong_tile_seq`

## Requirements
- R1: While reset is asserted and after it is released, `res_valid` is 0 and `res_data` is all zeros until the first tile completes.
- R2: Each bank entry k holds step k of a tile: A[i][k] in `wr_a[8i +: 8]` and B[k][j] in `wr_b[8j +: 8]`, both two's complement. A completed tile yields C[i][j] = sum over k of A[i][k]·B[k][j], as a signed AW-bit value in `res_data[AW·(i·N+j) +: AW]`.
- R3: If `start` is high in cycle c0 while the sequencer is idle, `res_valid` is high in exactly cycle c0+K+M+N+2. Inside the block, the clear strobe goes with the first valid step of every tile and never without valid.
- R4: Host writes made while a tile streams or drains do not change that tile's result.
- R5: Writes always land in the bank that is shadow in the cycle of the write. The swap takes effect at the end of the cycle after `start`, so the tile most recently loaded is the one the next start computes.
- R6: A `start` seen while a tile is in progress is held pending, and several such pulses merge into one. When M+N>2, the pending tile's `res_valid` comes K+M+N−1 cycles after the previous tile's.
- R7: `res_data` changes only in the cycle in which `res_valid` is high, and holds its value otherwise.
- R8: `res_valid` is high for one cycle at a time and pulses exactly once per started tile.
- R9: Full-range signed operands, including −128·−128 and −128·127 summed over K steps, give exact results.
- R10: Between the last valid step of one tile and the first of the next, the array receives at least (M−1)+(N−1) idle steps. Tiles launched back to back both produce correct results, and every tile starts from a cleared accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to swap banks and compute the tile in the shadow bank |
| wr_en | input | 1 | Host write enable into the shadow bank |
| wr_addr | input | $clog2(K) | Step index k of the entry being written |
| wr_a | input | M·DW | A column for step k, row i in byte i |
| wr_b | input | N·DW | B row for step k, column j in byte j |
| res_valid | output | 1 | One-cycle pulse when `res_data` has been updated |
| res_data | output | M·N·AW | Packed result matrix, element (i,j) at index i·N+j |

## Verification
A wrong bank select shows up at once as a result that matches the previously loaded tile, or a tile half-overwritten by host writes, in the very next `res_valid` cycle. A slipped strobe or a skewed delay line corrupts the sums. A missing clear makes a second tile carry the first tile's sums. Either error is visible in the first result after the fault. A fault in the step counter or the drain counter moves the `res_valid` pulse away from its exact cycle. A lost or duplicated pending start changes the number of pulses in the observation window. Each case is caught on that tile's own result.

// File: rtl/tile_seq_pkg.sv
package tile_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SWAP   = 2'd1,
    ST_STREAM = 2'd2,
    ST_DRAIN  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/seq_delay.sv
// Fixed-depth register pipeline, DEPTH >= 1.
module seq_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] sr [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < DEPTH; s++) sr[s] <= '0;
    end else begin
      sr[0] <= d;
      for (int s = 1; s < DEPTH; s++) sr[s] <= sr[s-1];
    end
  end

  assign q = sr[DEPTH-1];
endmodule

// File: rtl/seq_pe.sv
// One multiply-accumulate cell; accumulates only on valid steps.
module seq_pe #(
  parameter int DW = 8,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          en,
  input  logic          clr,
  output logic [AW-1:0] acc
);
  logic signed [2*DW-1:0] prod;
  logic signed [AW-1:0]   prod_x;

  assign prod   = $signed(a) * $signed(b);
  assign prod_x = {{(AW-2*DW){prod[2*DW-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst)       acc <= '0;
    else if (en)   acc <= clr ? prod_x : ($signed(acc) + prod_x);
  end
endmodule

// File: rtl/seq_array.sv
// Output-stationary wavefront array with boundary skew and strobe taps.
module seq_array #(
  parameter int M  = 3,
  parameter int N  = 3,
  parameter int K  = 3,
  parameter int DW = 8,
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [M*DW-1:0] a_vec,
  input  logic [N*DW-1:0] b_vec,
  input  logic            step_v,
  input  logic            step_clr,
  output logic            done,
  output logic [M*N*AW-1:0] c_vec
);
  localparam int TAPS  = M + N - 1;
  localparam int DONE_D = K + M + N - 2;

  logic [1:0]    strb [TAPS];
  logic [DW-1:0] a_h  [M][N];
  logic [DW-1:0] b_v  [M][N];

  assign strb[0] = {step_v, step_clr};

  for (genvar d = 1; d < TAPS; d++) begin : g_tap
    seq_delay #(.W(2), .DEPTH(d)) u_tap (
      .clk(clk), .rst(rst), .d({step_v, step_clr}), .q(strb[d])
    );
  end

  for (genvar i = 0; i < M; i++) begin : g_rskew
    if (i == 0) begin : g_direct
      assign a_h[0][0] = a_vec[0 +: DW];
    end else begin : g_dly
      seq_delay #(.W(DW), .DEPTH(i)) u_askew (
        .clk(clk), .rst(rst), .d(a_vec[i*DW +: DW]), .q(a_h[i][0])
      );
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_cskew
    if (j == 0) begin : g_direct
      assign b_v[0][0] = b_vec[0 +: DW];
    end else begin : g_dly
      seq_delay #(.W(DW), .DEPTH(j)) u_bskew (
        .clk(clk), .rst(rst), .d(b_vec[j*DW +: DW]), .q(b_v[0][j])
      );
    end
  end

  for (genvar i = 0; i < M; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      seq_pe #(.DW(DW), .AW(AW)) u_pe (
        .clk(clk), .rst(rst),
        .a(a_h[i][j]), .b(b_v[i][j]),
        .en(strb[i+j][1]), .clr(strb[i+j][0]),
        .acc(c_vec[(i*N+j)*AW +: AW])
      );
      if (j < N - 1) begin : g_apass
        seq_delay #(.W(DW), .DEPTH(1)) u_ap (
          .clk(clk), .rst(rst), .d(a_h[i][j]), .q(a_h[i][j+1])
        );
      end
      if (i < M - 1) begin : g_bpass
        seq_delay #(.W(DW), .DEPTH(1)) u_bp (
          .clk(clk), .rst(rst), .d(b_v[i][j]), .q(b_v[i+1][j])
        );
      end
    end
  end

  seq_delay #(.W(1), .DEPTH(DONE_D)) u_done (
    .clk(clk), .rst(rst), .d(step_v), .q(done)
  );
endmodule

// File: rtl/seq_bank.sv
// Two operand banks in one memory; host writes go to the shadow half,
// reads come from the active half through a registered port.
module seq_bank #(
  parameter int K  = 3,
  parameter int EW = 48,
  parameter int KA = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [KA-1:0] wr_addr,
  input  logic [EW-1:0] wr_data,
  input  logic          act_sel,
  input  logic [KA-1:0] rd_addr,
  output logic [EW-1:0] rd_data
);
  logic [EW-1:0] mem [2*K];
  logic [KA:0]   wr_idx, rd_idx;

  assign wr_idx = act_sel ? {1'b0, wr_addr} : ({1'b0, wr_addr} + (KA+1)'(K));
  assign rd_idx = act_sel ? ({1'b0, rd_addr} + (KA+1)'(K)) : {1'b0, rd_addr};

  always_ff @(posedge clk) begin
    if (wr_en && (wr_addr < KA'(K))) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/seq_ctrl.sv
// Tile sequencer: swap, K streaming steps, drain gap, pending start.
module seq_ctrl
  import tile_seq_pkg::*;
#(
  parameter int K  = 3,
  parameter int G  = 4,
  parameter int KA = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          act_sel,
  output logic [KA-1:0] rd_addr,
  output logic          step_v,
  output logic          step_clr
);
  localparam int DL  = (G > 0) ? G : 1;
  localparam int DCW = $clog2(DL + 1);
  localparam int GW  = $clog2(G + 2);

  seq_state_e     state;
  logic [KA-1:0]  kcnt;
  logic [DCW-1:0] dcnt;
  logic           pend;

  assign rd_addr = kcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      act_sel  <= 1'b0;
      kcnt     <= '0;
      dcnt     <= '0;
      pend     <= 1'b0;
      step_v   <= 1'b0;
      step_clr <= 1'b0;
    end else begin
      step_v   <= (state == ST_STREAM);
      step_clr <= (state == ST_STREAM) && (kcnt == '0);
      case (state)
        ST_IDLE: begin
          if (start) state <= ST_SWAP;
        end
        ST_SWAP: begin
          act_sel <= ~act_sel;
          kcnt    <= '0;
          state   <= ST_STREAM;
          if (start) pend <= 1'b1;
        end
        ST_STREAM: begin
          if (kcnt == KA'(K - 1)) begin
            state <= ST_DRAIN;
            dcnt  <= '0;
          end else begin
            kcnt <= kcnt + 1'b1;
          end
          if (start) pend <= 1'b1;
        end
        ST_DRAIN: begin
          if (dcnt == DCW'(DL - 1)) begin
            pend  <= 1'b0;
            state <= (start || pend) ? ST_SWAP : ST_IDLE;
          end else begin
            dcnt <= dcnt + 1'b1;
            if (start) pend <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Idle-step counter seen by the array, saturating at G.
  logic [GW-1:0] idle_cnt;
  always_ff @(posedge clk) begin
    if (rst)                      idle_cnt <= GW'(G);
    else if (step_v)              idle_cnt <= '0;
    else if (idle_cnt < GW'(G))   idle_cnt <= idle_cnt + 1'b1;
  end

  // R5: every swap cycle flips the active bank.
  a_r5_swap_flips: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SWAP) |=> (act_sel != $past(act_sel)));

  // R3: the first valid step of a tile carries the clear.
  a_r3_clr_on_first: assert property (@(posedge clk) disable iff (rst)
    $rose(step_v) |-> step_clr);

  // R3: clear never appears without valid.
  a_r3_clr_needs_v: assert property (@(posedge clk) disable iff (rst)
    step_clr |-> step_v);

  // R10: enough idle steps before each new tile enters the array.
  a_r10_launch_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(step_v) |-> (idle_cnt >= GW'(G)));
endmodule

// File: rtl/pingpong_tile_seq.sv
module pingpong_tile_seq #(
  parameter int M  = 3,
  parameter int N  = 3,
  parameter int K  = 3,
  parameter int DW = 8,
  parameter int AW = 32,
  parameter int KA = (K > 1) ? $clog2(K) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr_en,
  input  logic [KA-1:0]     wr_addr,
  input  logic [M*DW-1:0]   wr_a,
  input  logic [N*DW-1:0]   wr_b,
  output logic              res_valid,
  output logic [M*N*AW-1:0] res_data
);
  localparam int EW = (M + N) * DW;
  localparam int G  = (M - 1) + (N - 1);

  logic              act_sel;
  logic [KA-1:0]     rd_addr;
  logic [EW-1:0]     rd_data;
  logic              step_v, step_clr;
  logic              done, done_q;
  logic [M*N*AW-1:0] c_vec;

  seq_bank #(.K(K), .EW(EW), .KA(KA)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data({wr_b, wr_a}),
    .act_sel(act_sel), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  seq_ctrl #(.K(K), .G(G), .KA(KA)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .act_sel(act_sel), .rd_addr(rd_addr),
    .step_v(step_v), .step_clr(step_clr)
  );

  seq_array #(.M(M), .N(N), .K(K), .DW(DW), .AW(AW)) u_array (
    .clk(clk), .rst(rst),
    .a_vec(rd_data[M*DW-1:0]), .b_vec(rd_data[EW-1:M*DW]),
    .step_v(step_v), .step_clr(step_clr),
    .done(done), .c_vec(c_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q    <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      done_q    <= done;
      res_valid <= done && !done_q;
      if (done && !done_q) res_data <= c_vec;
    end
  end

  // R8: result-ready is a single-cycle pulse.
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R7: the result register only moves together with the pulse.
  a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> $stable(res_data));
endmodule

// File: tb/tb_pingpong_tile_seq.sv
`timescale 1ns/1ps
module tb_pingpong_tile_seq;
  localparam int M  = 3;
  localparam int N  = 3;
  localparam int K  = 3;
  localparam int DW = 8;
  localparam int AW = 32;
  localparam int KA = (K > 1) ? $clog2(K) : 1;
  localparam int LAT = K + M + N + 2;
  localparam int PER = K + M + N - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              wr_en = 1'b0;
  logic [KA-1:0]     wr_addr = '0;
  logic [M*DW-1:0]   wr_a = '0;
  logic [N*DW-1:0]   wr_b = '0;
  logic              res_valid;
  logic [M*N*AW-1:0] res_data;

  pingpong_tile_seq #(.M(M), .N(N), .K(K), .DW(DW), .AW(AW)) dut (
    .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_a(wr_a), .wr_b(wr_b), .res_valid(res_valid), .res_data(res_data)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int unsigned seed = 32'd20250701;
  int SA [2][M][K];
  int SB [2][K][N];

  task automatic chk(input bit ok, input string req, input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'hFF) - 128;
  endfunction

  task automatic fill(input int s, input int mode);
    for (int i = 0; i < M; i++)
      for (int k = 0; k < K; k++)
        case (mode)
          0: SA[s][i][k] = (i == k) ? 1 : 0;
          1: SA[s][i][k] = rnd8();
          2: SA[s][i][k] = -128;
          3: SA[s][i][k] = 2*i - 3*k + 1;
          default: SA[s][i][k] = ((i + k) % 2 == 0) ? -128 : 127;
        endcase
    for (int k = 0; k < K; k++)
      for (int j = 0; j < N; j++)
        case (mode)
          0: SB[s][k][j] = k*N + j + 1;
          1: SB[s][k][j] = rnd8();
          2: SB[s][k][j] = -128;
          3: SB[s][k][j] = 3*(k + j) - 5;
          default: SB[s][k][j] = 127;
        endcase
  endtask

  task automatic drive_entry(input int s, input int k);
    wr_en   = 1'b1;
    wr_addr = KA'(k);
    for (int i = 0; i < M; i++) wr_a[i*DW +: DW] = 8'(SA[s][i][k]);
    for (int j = 0; j < N; j++) wr_b[j*DW +: DW] = 8'(SB[s][k][j]);
  endtask

  task automatic preload(input int s);
    for (int k = 0; k < K; k++) begin
      drive_entry(s, k);
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic check_res(input int s, input string req);
    for (int i = 0; i < M; i++)
      for (int j = 0; j < N; j++) begin
        longint exp = 0;
        longint got;
        for (int k = 0; k < K; k++) exp += SA[s][i][k] * SB[s][k][j];
        got = longint'($signed(res_data[AW*(i*N+j) +: AW]));
        chk(got == exp, req, got, exp);
      end
  endtask

  // Cycle n = 0 is the start cycle; outputs are sampled before inputs change.
  task automatic run_tile(input int s0, input bit load_next, input bit extra,
                          input int exp_n, input string req);
    int hits [2];
    int cnt = 0;
    hits[0] = -1;
    hits[1] = -1;
    for (int n = 0; n < LAT + PER + 4; n++) begin
      if (res_valid) begin
        if (cnt < 2) begin
          hits[cnt] = n;
          check_res(s0 + cnt, req);
        end
        cnt++;
      end
      start = (n == 0) || (extra && (n == K + 2 || n == K + 3));
      if (load_next && n >= 2 && n < 2 + K) drive_entry(s0 + 1, n - 2);
      else wr_en = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    wr_en = 1'b0;
    chk(cnt == exp_n, "R8 pulse count", cnt, exp_n);
    chk(hits[0] == LAT, "R3 first result cycle", hits[0], LAT);
    if (exp_n == 2) chk(hits[1] == LAT + PER, "R6 pending result cycle", hits[1], LAT + PER);
  endtask

  task automatic t_reset();
    chk(res_valid == 1'b0, "R1 res_valid after reset", res_valid, 0);
    chk(res_data == '0, "R1 res_data after reset", (res_data == '0) ? 0 : 1, 0);
  endtask

  task automatic t_single(input int mode, input string req);
    fill(0, mode);
    preload(0);
    run_tile(0, 1'b0, 1'b0, 1, req);
    repeat (3) @(negedge clk);
    check_res(0, "R7 held result");
  endtask

  task automatic t_overlap();
    fill(0, 1);
    fill(1, 3);
    preload(0);
    run_tile(0, 1'b1, 1'b0, 1, "R4 shadow writes during tile");
    run_tile(1, 1'b0, 1'b0, 1, "R5 R10 next tile from swapped bank");
  endtask

  task automatic t_pending();
    fill(0, 3);
    fill(1, 1);
    preload(0);
    run_tile(0, 1'b1, 1'b1, 2, "R6 R10 pending back-to-back");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single(0, "R2 identity x ramp");
    t_single(1, "R2 random");
    t_single(3, "R2 mixed ramp");
    t_single(2, "R9 min x min");
    t_single(4, "R9 min x max alternating");
    t_overlap();
    t_pending();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule